// File: doc/BRIEF.md
# Viterbi Add-Compare-Select Unit

This block performs the add-compare-select step of a Viterbi decoder directly on a bank of 40-bit accumulators. Each operation names two source accumulators. It adds a branch metric to each of their path metrics, keeps the smaller sum, subtracts a common normalization offset from it, and writes the result back in place into one of the two sources. Every such step emits a one-bit decision, and that decision is shifted into a 16-bit traceback register. A trellis controller outside this block reads the traceback register.

A second mode, split mode, prepares symbol distances in the same datapath. It treats the low 32 bits of each source as two independent signed 16-bit lanes. It adds or subtracts the lanes pairwise with per-lane saturation and writes the packed result back. Other datapath logic fills and inspects the accumulators through a load port and a registered read port.

Top module: `viterbi_acs`

## Requirements
- R1: After synchronous reset (`rst` high at a clock edge) every accumulator, `tb_reg`, `dec_out` and `dec_valid` read as zero.
- R2: With `op_en` low, `ld_en` writes `ld_data` into accumulator `ld_idx` at the clock edge. `rd_data` presents accumulator `rd_idx` one clock after `rd_idx` is applied.
- R3: In path mode (`op_en`=1, `op_split`=0), the unit forms sum_a = acc[`src_a`] + sign-extended `bm_a` and sum_b = acc[`src_b`] + sign-extended `bm_b`, both in 40-bit two's complement with wraparound. It compares them as signed values. The smaller sum survives, and on equality the `src_a` sum survives.
- R4: After each path-mode operation, `dec_out` is 1 when the `src_b` sum survived and 0 when the `src_a` sum survived, and `dec_valid` is high for exactly that one cycle.
- R5: The surviving sum minus the zero-extended `norm` is written to `src_a` when `dst_b`=0 and to `src_b` when `dst_b`=1. All other accumulators keep their values.
- R6: `norm` is applied after the compare, so it never changes which sum survives.
- R7: Each path-mode operation updates `tb_reg` to {`tb_reg`[14:0], decision}, with the newest decision in bit 0. In every other cycle `tb_reg` holds its value.
- R8: In split mode (`op_en`=1, `op_split`=1), lane 0 is bits [15:0] and lane 1 is bits [31:16]. Each result lane is a+b, or a−b when `split_sub`=1, taken from the matching lanes of acc[`src_a`] (a) and acc[`src_b`] (b). Each lane saturates independently to [−32768, 32767] with no carry between lanes. Bits [39:32] are copies of bit 31. The result goes to the source that `dst_b` selects.
- R9: A split-mode operation ignores `bm_a`, `bm_b` and `norm`. It leaves `tb_reg` unchanged and raises no `dec_valid`.
- R10: When `op_en` and `ld_en` are both high in the same cycle, the load has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Load accumulator strobe |
| ld_idx | input | 3 | Accumulator index to load |
| ld_data | input | 40 | Value to load |
| op_en | input | 1 | Start an operation this cycle |
| op_split | input | 1 | 1 = split 16-bit lane mode, 0 = path mode |
| split_sub | input | 1 | Split mode: subtract lanes instead of adding |
| src_a | input | 3 | First source accumulator index |
| src_b | input | 3 | Second source accumulator index |
| dst_b | input | 1 | Write result to `src_b` (1) or `src_a` (0) |
| bm_a | input | 24 | Signed branch metric for the first source |
| bm_b | input | 24 | Signed branch metric for the second source |
| norm | input | 24 | Unsigned normalization offset |
| rd_idx | input | 3 | Accumulator index to read |
| rd_data | output | 40 | Registered accumulator read data |
| dec_out | output | 1 | Last decision (1 = second source survived) |
| dec_valid | output | 1 | Decision produced in the previous cycle |
| tb_reg | output | 16 | Traceback shift register |

## Verification
The bound checker watches the decision handshake and the traceback register on every cycle. It checks that `dec_valid` follows exactly the path-mode operations, that `tb_reg` shifts by one with the new bit equal to `dec_out`, and that `tb_reg` stays still on split, load and idle cycles. It also checks that reset clears both. The arithmetic can only be shown by the bench's scenarios, because each case needs a chosen operand value to expose it. These include the signed compare, the tie rule, wraparound at the 40-bit boundary, normalization, per-lane saturation without carry, the write-back destination and load suppression during an operation.

// File: rtl/acs_pkg.sv
package acs_pkg;
  localparam int ACS_ACC_W  = 40;
  localparam int ACS_N_ACC  = 8;
  localparam int ACS_BM_W   = 24;
  localparam int ACS_LANE_W = 16;
  localparam int ACS_TB_W   = 16;

  typedef enum logic {
    PICK_FIRST  = 1'b0,
    PICK_SECOND = 1'b1
  } pick_e;
endpackage

// File: rtl/acs_acc_file.sv
module acs_acc_file #(
  parameter int N  = 8,
  parameter int W  = 40,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [IW-1:0] ra_a,
  output logic [W-1:0]  rd_a,
  input  logic [IW-1:0] ra_b,
  output logic [W-1:0]  rd_b,
  input  logic [IW-1:0] rq_addr,
  output logic [W-1:0]  rq_data
);
  logic [W-1:0] mem [N];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) mem[i] <= '0;
      rq_data <= '0;
    end else begin
      if (we) mem[waddr] <= wdata;
      rq_data <= mem[rq_addr];
    end
  end

  assign rd_a = mem[ra_a];
  assign rd_b = mem[ra_b];
endmodule

// File: rtl/acs_compare.sv
module acs_compare
  import acs_pkg::*;
#(
  parameter int W    = 40,
  parameter int BM_W = 24
) (
  input  logic [W-1:0]    pm_a,
  input  logic [W-1:0]    pm_b,
  input  logic [BM_W-1:0] bm_a,
  input  logic [BM_W-1:0] bm_b,
  input  logic [BM_W-1:0] norm,
  output pick_e           pick,
  output logic [W-1:0]    result
);
  localparam int EXT = W - BM_W;

  logic [W-1:0] sum_a, sum_b, winner;

  assign sum_a = pm_a + {{EXT{bm_a[BM_W-1]}}, bm_a};
  assign sum_b = pm_b + {{EXT{bm_b[BM_W-1]}}, bm_b};

  // strict less-than keeps the first source on equality
  assign pick   = ($signed(sum_b) < $signed(sum_a)) ? PICK_SECOND : PICK_FIRST;
  assign winner = (pick == PICK_SECOND) ? sum_b : sum_a;
  assign result = winner - {{EXT{1'b0}}, norm};
endmodule

// File: rtl/acs_split_lane.sv
module acs_split_lane #(
  parameter int LW = 16
) (
  input  logic [LW-1:0] a,
  input  logic [LW-1:0] b,
  input  logic          sub,
  output logic [LW-1:0] y
);
  logic signed [LW:0] ax, bx, s;

  assign ax = $signed({a[LW-1], a});
  assign bx = $signed({b[LW-1], b});
  assign s  = sub ? (ax - bx) : (ax + bx);

  always_comb begin
    if (s[LW] != s[LW-1])
      y = s[LW] ? {1'b1, {(LW-1){1'b0}}} : {1'b0, {(LW-1){1'b1}}};
    else
      y = s[LW-1:0];
  end
endmodule

// File: rtl/viterbi_acs.sv
module viterbi_acs
  import acs_pkg::*;
#(
  parameter int ACC_W  = ACS_ACC_W,
  parameter int N_ACC  = ACS_N_ACC,
  parameter int BM_W   = ACS_BM_W,
  parameter int LANE_W = ACS_LANE_W,
  parameter int TB_W   = ACS_TB_W,
  parameter int IDX_W  = $clog2(N_ACC)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_en,
  input  logic [IDX_W-1:0]  ld_idx,
  input  logic [ACC_W-1:0]  ld_data,
  input  logic              op_en,
  input  logic              op_split,
  input  logic              split_sub,
  input  logic [IDX_W-1:0]  src_a,
  input  logic [IDX_W-1:0]  src_b,
  input  logic              dst_b,
  input  logic [BM_W-1:0]   bm_a,
  input  logic [BM_W-1:0]   bm_b,
  input  logic [BM_W-1:0]   norm,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [ACC_W-1:0]  rd_data,
  output logic              dec_out,
  output logic              dec_valid,
  output logic [TB_W-1:0]   tb_reg
);
  localparam int NLANES = 2;
  localparam int PACK_W = NLANES * LANE_W;
  localparam int GUARD  = ACC_W - PACK_W;

  logic [ACC_W-1:0] pm_a, pm_b, path_res, split_res, wr_data;
  logic [IDX_W-1:0] wr_idx;
  logic             wr_en, path_op;
  pick_e            pick;

  acs_acc_file #(.N(N_ACC), .W(ACC_W), .IW(IDX_W)) u_file (
    .clk(clk), .rst(rst),
    .we(wr_en), .waddr(wr_idx), .wdata(wr_data),
    .ra_a(src_a), .rd_a(pm_a),
    .ra_b(src_b), .rd_b(pm_b),
    .rq_addr(rd_idx), .rq_data(rd_data)
  );

  acs_compare #(.W(ACC_W), .BM_W(BM_W)) u_cmp (
    .pm_a(pm_a), .pm_b(pm_b), .bm_a(bm_a), .bm_b(bm_b),
    .norm(norm), .pick(pick), .result(path_res)
  );

  for (genvar l = 0; l < NLANES; l++) begin : g_lane
    acs_split_lane #(.LW(LANE_W)) u_lane (
      .a(pm_a[l*LANE_W +: LANE_W]),
      .b(pm_b[l*LANE_W +: LANE_W]),
      .sub(split_sub),
      .y(split_res[l*LANE_W +: LANE_W])
    );
  end

  if (GUARD > 0) begin : g_guard
    assign split_res[ACC_W-1:PACK_W] = {GUARD{split_res[PACK_W-1]}};
  end

  // an operation owns the write port; a concurrent load is dropped
  assign path_op = op_en & ~op_split;
  assign wr_en   = op_en | ld_en;
  assign wr_idx  = op_en ? (dst_b ? src_b : src_a) : ld_idx;
  assign wr_data = op_en ? (op_split ? split_res : path_res) : ld_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_out   <= 1'b0;
      dec_valid <= 1'b0;
      tb_reg    <= '0;
    end else begin
      dec_valid <= path_op;
      if (path_op) begin
        dec_out <= pick;
        tb_reg  <= {tb_reg[TB_W-2:0], pick};
      end
    end
  end
endmodule

// File: rtl/acs_checker.sv
module acs_checker #(
  parameter int TB_W = 16
) (
  input logic            clk,
  input logic            rst,
  input logic            op_en,
  input logic            op_split,
  input logic            dec_out,
  input logic            dec_valid,
  input logic [TB_W-1:0] tb_reg
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (tb_reg == '0) && !dec_valid && !dec_out);

  assert_dec_valid_follows_op_R4: assert property (@(posedge clk) disable iff (rst)
    (op_en && !op_split) |=> dec_valid);

  assert_no_dec_without_path_R9: assert property (@(posedge clk) disable iff (rst)
    !(op_en && !op_split) |=> !dec_valid);

  assert_tb_shift_R7: assert property (@(posedge clk) disable iff (rst)
    (op_en && !op_split) |=>
      (tb_reg[TB_W-1:1] == $past(tb_reg[TB_W-2:0])) && (tb_reg[0] == dec_out));

  assert_tb_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !(op_en && !op_split) |=> $stable(tb_reg));
endmodule

bind viterbi_acs acs_checker #(.TB_W(TB_W)) u_acs_checker (
  .clk(clk), .rst(rst), .op_en(op_en), .op_split(op_split),
  .dec_out(dec_out), .dec_valid(dec_valid), .tb_reg(tb_reg)
);

// File: tb/test_viterbi_acs.sv
module test_viterbi_acs;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst, ld_en, op_en, op_split, split_sub, dst_b;
  logic [2:0]  ld_idx, src_a, src_b, rd_idx;
  logic [39:0] ld_data, rd_data;
  logic [23:0] bm_a, bm_b, norm;
  logic        dec_out, dec_valid;
  logic [15:0] tb_reg;

  int total = 0;
  int bad   = 0;
  logic [39:0] mdl [8];
  logic [15:0] tb_exp;

  always #(CLK_PERIOD/2) clk = ~clk;

  viterbi_acs i_viterbi_acs (
    .clk(clk), .rst(rst), .ld_en(ld_en), .ld_idx(ld_idx), .ld_data(ld_data),
    .op_en(op_en), .op_split(op_split), .split_sub(split_sub),
    .src_a(src_a), .src_b(src_b), .dst_b(dst_b),
    .bm_a(bm_a), .bm_b(bm_b), .norm(norm), .rd_idx(rd_idx),
    .rd_data(rd_data), .dec_out(dec_out), .dec_valid(dec_valid), .tb_reg(tb_reg)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic read_chk(input int idx, input string req);
    @(negedge clk) rd_idx = 3'(idx);
    @(negedge clk);
    chk(req, 64'(rd_data), 64'(mdl[idx]));
  endtask

  task automatic do_load(input int idx, input logic [39:0] val);
    @(negedge clk) begin ld_en = 1; ld_idx = 3'(idx); ld_data = val; end
    @(negedge clk) ld_en = 0;
    mdl[idx] = val;
  endtask

  function automatic logic [39:0] split_ref(logic [39:0] a, logic [39:0] b, bit sub);
    logic [39:0] r = '0;
    for (int l = 0; l < 2; l++) begin
      logic signed [15:0] x = a[l*16 +: 16];
      logic signed [15:0] y = b[l*16 +: 16];
      int s = sub ? int'(x) - int'(y) : int'(x) + int'(y);
      if (s > 32767) s = 32767;
      if (s < -32768) s = -32768;
      r[l*16 +: 16] = s[15:0];
    end
    r[39:32] = {8{r[31]}};
    return r;
  endfunction

  task automatic do_acs(input int a, input int b, input logic [23:0] ba, input logic [23:0] bb,
                        input logic [23:0] nrm, input bit db, input string req);
    logic [39:0] sa = mdl[a] + {{16{ba[23]}}, ba};
    logic [39:0] sb = mdl[b] + {{16{bb[23]}}, bb};
    bit pk = $signed(sb) < $signed(sa);
    int dst = db ? b : a;
    @(negedge clk) begin
      op_en = 1; op_split = 0; src_a = 3'(a); src_b = 3'(b);
      bm_a = ba; bm_b = bb; norm = nrm; dst_b = db;
    end
    @(negedge clk) op_en = 0;
    mdl[dst] = (pk ? sb : sa) - {16'h0, nrm};
    tb_exp = {tb_exp[14:0], pk};
    chk({req, " R4 decision"}, 64'(dec_out), 64'(pk));
    chk({req, " R4 dec_valid"}, 64'(dec_valid), 64'(1));
    chk({req, " R7 traceback"}, 64'(tb_reg), 64'(tb_exp));
    read_chk(dst, {req, " R5 writeback"});
  endtask

  task automatic do_split(input int a, input int b, input bit sub, input bit db, input string req);
    int dst = db ? b : a;
    logic [39:0] exp = split_ref(mdl[a], mdl[b], sub);
    @(negedge clk) begin
      op_en = 1; op_split = 1; split_sub = sub; src_a = 3'(a); src_b = 3'(b);
      dst_b = db; bm_a = 24'h00_1234; bm_b = 24'hFF_0000; norm = 24'h00_0777;
    end
    @(negedge clk) begin op_en = 0; op_split = 0; end
    mdl[dst] = exp;
    chk({req, " R9 no dec_valid"}, 64'(dec_valid), 64'(0));
    chk({req, " R9 tb held"}, 64'(tb_reg), 64'(tb_exp));
    read_chk(dst, {req, " R8 lanes"});
  endtask

  task automatic t_reset;
    chk("R1 tb_reg", 64'(tb_reg), 64'(0));
    chk("R1 dec_valid", 64'(dec_valid), 64'(0));
    chk("R1 dec_out", 64'(dec_out), 64'(0));
    for (int i = 0; i < 8; i++) read_chk(i, "R1 acc zero");
  endtask

  task automatic t_load;
    do_load(0, 40'd100);
    do_load(1, 40'd250);
    do_load(2, -40'sd50);
    do_load(3, 40'h7F_FFFF_FFF0);
    for (int i = 0; i < 4; i++) read_chk(i, "R2 load/read");
  endtask

  task automatic t_path;
    do_acs(0, 1, 24'd10, -24'sd200, 24'd0, 0, "R3 second wins");
    do_acs(0, 1, 24'd20, -24'sd180, 24'd5, 1, "R3 tie first wins");
    do_acs(2, 0, 24'd0, 24'd0, 24'd0, 0, "R3 signed compare");
    do_acs(3, 1, 24'h20, 24'd0, 24'h10, 0, "R3 40-bit wrap");
    read_chk(2, "R5 other untouched");
  endtask

  task automatic t_norm;
    // with or without the offset the decision stays the same
    do_load(6, 40'd1000);
    do_load(7, 40'd1000);
    do_acs(6, 7, 24'd3, 24'd4, 24'hFF_FFFF, 1, "R6 large norm");
  endtask

  task automatic t_split;
    do_load(4, {8'h00, 16'h7FF0, 16'h0001});
    do_load(5, {8'h00, 16'h0020, 16'hFFFF});
    do_split(4, 5, 0, 1, "R8 add sat no carry");
    do_load(5, {8'h00, 16'h0020, 16'hFFFF});
    do_split(4, 5, 1, 0, "R8 sub");
    do_load(6, {8'h00, 16'h8005, 16'h8000});
    do_load(7, {8'h00, 16'h0010, 16'h0001});
    do_split(6, 7, 1, 0, "R8 neg sat guard");
  endtask

  task automatic t_priority;
    do_load(5, 40'd77);
    @(negedge clk) begin
      op_en = 1; op_split = 0; src_a = 3'd0; src_b = 3'd1; dst_b = 0;
      bm_a = 0; bm_b = 0; norm = 0;
      ld_en = 1; ld_idx = 3'd5; ld_data = 40'd999;
    end
    begin
      logic [39:0] sa = mdl[0], sb = mdl[1];
      bit pk = $signed(sb) < $signed(sa);
      @(negedge clk) begin op_en = 0; ld_en = 0; end
      mdl[0] = pk ? sb : sa;
      tb_exp = {tb_exp[14:0], pk};
    end
    read_chk(5, "R10 load dropped");
    read_chk(0, "R10 op result kept");
  endtask

  task automatic t_tb_long;
    do_load(6, 40'd5000);
    do_load(7, 40'd5000);
    for (int i = 0; i < 18; i++)
      do_acs(6, 7, 24'd0, (i % 3 == 0) ? -24'sd40 : 24'd40, 24'd0, 0, "R7 long shift");
    @(negedge clk);
    chk("R7 idle hold", 64'(tb_reg), 64'(tb_exp));
    chk("R4 pulse ends", 64'(dec_valid), 64'(0));
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst = 1; ld_en = 0; op_en = 0; op_split = 0; split_sub = 0; dst_b = 0;
    ld_idx = 0; ld_data = 0; src_a = 0; src_b = 0; bm_a = 0; bm_b = 0;
    norm = 0; rd_idx = 0;
    for (int i = 0; i < 8; i++) mdl[i] = '0;
    tb_exp = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 0;
    t_reset();
    t_load();
    t_path();
    t_norm();
    t_split();
    t_priority();
    t_tb_long();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule